// File: doc/BRIEF.md
# Two-Level Physical Register File

This block stores the physical register values of an out-of-order core in two levels. A small, fast first level holds only the values that functional units still have to read. A larger second level, indexed directly by physical tag, keeps values that have no pending readers. These values may still be needed to rebuild precise state after a mispredicted branch or an exception. At dispatch, each instruction that writes a destination claims a first-level slot for its physical tag, together with an initial pending-consumer count. Instructions renamed later that source the tag raise the count. Each operand read through a read port lowers it.

Once a slot has been written and its count is zero, the value moves to the second level and the slot becomes free. If the slot runs out, allocation is refused and dispatch stalls. A restore request copies a second-level value back into a free slot with a fresh consumer count. A restore outranks allocation for free slots and reports busy while none is free. A free request, issued when the next writer of the logical register commits, drops the value from both levels. Rename tables, the reorder buffer and the functional units sit outside the block.

Top module: `tlrf_top`

## Requirements
- R1: After reset no slot is occupied and no tag is held in the second level: allocReady is 1, every rdHit is 0, and a restore request neither loads a slot nor raises rstrBusy.
- R2: An allocation (allocEn with allocReady high) occupies one free slot with allocTag and count allocCons, unwritten. allocReady is 0 exactly when every one of the L1_DEPTH slots is occupied or being claimed by a restore, and allocEn is then ignored.
- R3: A writeback on any of the ISSUE_W write ports stores wbData into the slot holding wbTag at the next edge. Each of the 2*ISSUE_W read ports returns rdHit=1 and that data in the same cycle for a written resident tag, and rdHit=0 for an unwritten or absent tag.
- R4: Each read port with rdEn and rdHit lowers the slot count by one, with all ports in one cycle adding up. addEn on a resident tag raises the count by one, so an add and a read in the same cycle leave it unchanged.
- R5: A written slot with count zero and no add in that cycle moves its value to the second level at the next edge and becomes free. Its tag then misses on the read ports.
- R6: A value moved to the second level is kept there. rstrEn on such a tag, with a slot free, loads the slot with the same data, marked written, with count rstrCons, so reads hit one cycle later. The second-level copy stays valid.
- R7: rstrBusy is 1 while rstrEn names a second-level tag and no slot is free, and no load happens. When exactly one slot is free, the restore takes it and allocReady is 0 in that cycle.
- R8: freeEn drops freeTag from the second level and, if present, from the first level. A later restore of that tag has no effect, and its slot is free again.
- R9: A restore of a tag that the second level does not hold is ignored: no slot is loaded and rstrBusy stays 0 even when the first level is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocEn | input | 1 | Dispatch allocation request |
| allocTag | input | TAG_W | Physical tag being allocated |
| allocCons | input | CNT_W | Initial pending-consumer count |
| allocReady | output | 1 | A slot is available for allocation |
| addEn | input | 1 | A consumer was renamed to addTag |
| addTag | input | TAG_W | Tag gaining a consumer |
| rdEn | input | RD_PORTS | Operand read strobe per port (decrements on hit) |
| rdTag | input | RD_PORTS*TAG_W | Tag per read port |
| rdData | output | RD_PORTS*DATA_W | Read data per port |
| rdHit | output | RD_PORTS | Tag written and resident in first level |
| wbEn | input | ISSUE_W | Writeback strobe per port |
| wbTag | input | ISSUE_W*TAG_W | Writeback tag per port |
| wbData | input | ISSUE_W*DATA_W | Writeback data per port |
| freeEn | input | 1 | Commit release request |
| freeTag | input | TAG_W | Tag to release |
| rstrEn | input | 1 | Recovery restore request |
| rstrTag | input | TAG_W | Tag to restore |
| rstrCons | input | CNT_W | Consumer count for the restored value |
| rstrBusy | output | 1 | Restore stalled for lack of a free slot |

## Verification
On every cycle, the assertions check the following: a moved slot's tag becomes valid in the second level, a freed tag is gone from it, a count never underflows under a hitting read, and allocation is never offered while a restore is stalled or every slot is full. Only the directed scenarios can show the data path end to end. These include the values returned after writeback and after a restore, the exact edge at which a drained value leaves the read ports, the summed decrement across several ports, and the effect of an add and a read in the same cycle. They also cover restore priority over allocation for the last free slot, and restores that are ignored after a free or for a tag never moved.

// File: rtl/tlrf_pkg.sv
package tlrf_pkg;
  parameter int ISSUE_W  = 2;
  parameter int RD_PORTS = 2 * ISSUE_W;
  parameter int L1_DEPTH = 4;
  parameter int NUM_TAGS = 16;
  parameter int DATA_W   = 32;
  parameter int CNT_W    = 3;
  localparam int TAG_W    = $clog2(NUM_TAGS);
  localparam int SLOT_W   = (L1_DEPTH > 1) ? $clog2(L1_DEPTH) : 1;
  localparam int WBSEL_W  = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [L1_DEPTH-1:0]              restoreLoad;
    logic [TAG_W-1:0]                 restoreTag;
    logic [L1_DEPTH-1:0]              wbHit;
    logic [L1_DEPTH-1:0][WBSEL_W-1:0] wbSel;
    logic [L1_DEPTH-1:0]              moveMask;
    logic [L1_DEPTH-1:0][TAG_W-1:0]   slotTag;
    logic [RD_PORTS-1:0][SLOT_W-1:0]  rdSlot;
  } strobes_t;
endpackage

// File: rtl/tlrf_ctrl.sv
module tlrf_ctrl
  import tlrf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          allocEn,
  input  logic [TAG_W-1:0]              allocTag,
  input  logic [CNT_W-1:0]              allocCons,
  output logic                          allocReady,
  input  logic                          addEn,
  input  logic [TAG_W-1:0]              addTag,
  input  logic [RD_PORTS-1:0]           rdEn,
  input  logic [RD_PORTS-1:0][TAG_W-1:0] rdTag,
  output logic [RD_PORTS-1:0]           rdHit,
  input  logic [ISSUE_W-1:0]            wbEn,
  input  logic [ISSUE_W-1:0][TAG_W-1:0] wbTag,
  input  logic                          freeEn,
  input  logic [TAG_W-1:0]              freeTag,
  input  logic                          rstrEn,
  input  logic [TAG_W-1:0]              rstrTag,
  input  logic [CNT_W-1:0]              rstrCons,
  output logic                          rstrBusy,
  output strobes_t                      strb
);
  logic [L1_DEPTH-1:0]             slotValid, slotWritten;
  logic [L1_DEPTH-1:0][TAG_W-1:0]  slotTag;
  logic [L1_DEPTH-1:0][CNT_W-1:0]  slotCnt;
  logic [NUM_TAGS-1:0]             l2Valid;

  logic [L1_DEPTH-1:0]             freeVec, rstrOh, allocAvail, allocOh;
  logic [L1_DEPTH-1:0]             addHit, freeHit, moveMask;
  logic [L1_DEPTH-1:0][CNT_W-1:0]  decCnt;
  logic                            rstrTake;

  function automatic logic [L1_DEPTH-1:0] lowestOne(input logic [L1_DEPTH-1:0] v);
    return v & (~v + L1_DEPTH'(1));
  endfunction

  always_comb begin
    freeVec    = ~slotValid;
    rstrTake   = rstrEn && l2Valid[rstrTag] && (|freeVec);
    rstrBusy   = rstrEn && l2Valid[rstrTag] && !(|freeVec);
    rstrOh     = lowestOne(freeVec) & {L1_DEPTH{rstrTake}};
    allocAvail = freeVec & ~rstrOh;
    allocReady = |allocAvail;
    allocOh    = lowestOne(allocAvail) & {L1_DEPTH{allocEn}};
  end

  always_comb begin
    strb.wbHit = '0;
    strb.wbSel = '0;
    for (int s = 0; s < L1_DEPTH; s++) begin
      addHit[s]  = addEn && slotValid[s] && (slotTag[s] == addTag);
      freeHit[s] = freeEn && slotValid[s] && (slotTag[s] == freeTag);
      moveMask[s] = slotValid[s] && slotWritten[s] && (slotCnt[s] == '0)
                    && !addHit[s] && !freeHit[s];
      for (int p = 0; p < ISSUE_W; p++) begin
        if (wbEn[p] && slotValid[s] && (slotTag[s] == wbTag[p])) begin
          strb.wbHit[s] = 1'b1;
          strb.wbSel[s] = WBSEL_W'(p);
        end
      end
    end
  end

  always_comb begin
    rdHit       = '0;
    strb.rdSlot = '0;
    decCnt      = '0;
    for (int r = 0; r < RD_PORTS; r++) begin
      for (int s = 0; s < L1_DEPTH; s++) begin
        if (slotValid[s] && slotWritten[s] && (slotTag[s] == rdTag[r])) begin
          rdHit[r]       = 1'b1;
          strb.rdSlot[r] = SLOT_W'(s);
          if (rdEn[r]) decCnt[s] = decCnt[s] + CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb.restoreLoad = rstrOh;
    strb.restoreTag  = rstrTag;
    strb.moveMask    = moveMask;
    strb.slotTag     = slotTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid   <= '0;
      slotWritten <= '0;
      slotTag     <= '0;
      slotCnt     <= '0;
      l2Valid     <= '0;
    end else begin
      for (int s = 0; s < L1_DEPTH; s++) begin
        if (freeHit[s] || moveMask[s]) begin
          slotValid[s]   <= 1'b0;
          slotWritten[s] <= 1'b0;
        end else if (rstrOh[s]) begin
          slotValid[s]   <= 1'b1;
          slotTag[s]     <= rstrTag;
          slotWritten[s] <= 1'b1;
          slotCnt[s]     <= rstrCons;
        end else if (allocOh[s]) begin
          slotValid[s]   <= 1'b1;
          slotTag[s]     <= allocTag;
          slotWritten[s] <= 1'b0;
          slotCnt[s]     <= allocCons;
        end else if (slotValid[s]) begin
          slotWritten[s] <= slotWritten[s] | strb.wbHit[s];
          slotCnt[s]     <= slotCnt[s] + CNT_W'(addHit[s]) - decCnt[s];
        end
        if (moveMask[s]) l2Valid[slotTag[s]] <= 1'b1;
      end
      if (|allocOh) l2Valid[allocTag] <= 1'b0;
      if (freeEn)   l2Valid[freeTag]  <= 1'b0;
    end
  end

  // R7: a stalled restore never coexists with an allocation offer
  assert_busy_blocks_alloc_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstrBusy |-> !allocReady);
  // R2: allocation offered only while some slot is unoccupied
  assert_ready_has_room_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocReady |-> ($countones(slotValid) < L1_DEPTH));
  // R8: a released tag is gone from the second level
  assert_free_drops_l2_R8: assert property (@(posedge clk) disable iff (!rstN)
    freeEn |=> !l2Valid[$past(freeTag)]);

  for (genvar s = 0; s < L1_DEPTH; s++) begin : gSlotChk
    // R5: a drained slot lands in the second level and frees
    assert_move_to_l2_R5: assert property (@(posedge clk) disable iff (!rstN)
      moveMask[s] |=> (l2Valid[$past(slotTag[s])] && !slotValid[s]));
    // R4: a hitting read never drives the count below zero
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[s] && (slotCnt[s] == '0)) |-> (decCnt[s] == '0));
    // R3: a written value stays written while resident
    assert_written_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[s] && slotWritten[s] && !moveMask[s] && !freeHit[s]) |=> slotWritten[s]);
  end
endmodule

// File: rtl/tlrf_data.sv
module tlrf_data
  import tlrf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  strobes_t                        strb,
  input  logic [ISSUE_W-1:0][DATA_W-1:0]  wbData,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rdData
);
  logic [L1_DEPTH-1:0][DATA_W-1:0] l1Data;
  logic [NUM_TAGS-1:0][DATA_W-1:0] l2Data;

  always_ff @(posedge clk) begin
    for (int s = 0; s < L1_DEPTH; s++) begin
      if (strb.restoreLoad[s])
        l1Data[s] <= l2Data[strb.restoreTag];
      else if (strb.wbHit[s])
        l1Data[s] <= wbData[strb.wbSel[s]];
      if (strb.moveMask[s])
        l2Data[strb.slotTag[s]] <= l1Data[s];
    end
  end

  always_comb begin
    for (int r = 0; r < RD_PORTS; r++) rdData[r] = l1Data[strb.rdSlot[r]];
  end

  // R6: at most one slot is refilled by a restore per cycle
  assert_restore_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.restoreLoad));
  // R6: a refilled slot is never also a writeback target
  assert_restore_no_wb_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.restoreLoad & strb.wbHit) == '0));
endmodule

// File: rtl/tlrf_top.sv
module tlrf_top
  import tlrf_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            allocEn,
  input  logic [TAG_W-1:0]                allocTag,
  input  logic [CNT_W-1:0]                allocCons,
  output logic                            allocReady,
  input  logic                            addEn,
  input  logic [TAG_W-1:0]                addTag,
  input  logic [RD_PORTS-1:0]             rdEn,
  input  logic [RD_PORTS-1:0][TAG_W-1:0]  rdTag,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rdData,
  output logic [RD_PORTS-1:0]             rdHit,
  input  logic [ISSUE_W-1:0]              wbEn,
  input  logic [ISSUE_W-1:0][TAG_W-1:0]   wbTag,
  input  logic [ISSUE_W-1:0][DATA_W-1:0]  wbData,
  input  logic                            freeEn,
  input  logic [TAG_W-1:0]                freeTag,
  input  logic                            rstrEn,
  input  logic [TAG_W-1:0]                rstrTag,
  input  logic [CNT_W-1:0]                rstrCons,
  output logic                            rstrBusy
);
  strobes_t strb;

  tlrf_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .allocEn(allocEn), .allocTag(allocTag), .allocCons(allocCons), .allocReady(allocReady),
    .addEn(addEn), .addTag(addTag),
    .rdEn(rdEn), .rdTag(rdTag), .rdHit(rdHit),
    .wbEn(wbEn), .wbTag(wbTag),
    .freeEn(freeEn), .freeTag(freeTag),
    .rstrEn(rstrEn), .rstrTag(rstrTag), .rstrCons(rstrCons), .rstrBusy(rstrBusy),
    .strb(strb)
  );

  tlrf_data uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wbData(wbData), .rdData(rdData)
  );
endmodule

// File: tb/tb_tlrf_top.sv
`timescale 1ns/1ps
module tb_tlrf_top;
  import tlrf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocEn = 1'b0;
  logic [TAG_W-1:0] allocTag = '0;
  logic [CNT_W-1:0] allocCons = '0;
  logic allocReady;
  logic addEn = 1'b0;
  logic [TAG_W-1:0] addTag = '0;
  logic [RD_PORTS-1:0] rdEn = '0;
  logic [RD_PORTS-1:0][TAG_W-1:0] rdTag = '0;
  logic [RD_PORTS-1:0][DATA_W-1:0] rdData;
  logic [RD_PORTS-1:0] rdHit;
  logic [ISSUE_W-1:0] wbEn = '0;
  logic [ISSUE_W-1:0][TAG_W-1:0] wbTag = '0;
  logic [ISSUE_W-1:0][DATA_W-1:0] wbData = '0;
  logic freeEn = 1'b0;
  logic [TAG_W-1:0] freeTag = '0;
  logic rstrEn = 1'b0;
  logic [TAG_W-1:0] rstrTag = '0;
  logic [CNT_W-1:0] rstrCons = '0;
  logic rstrBusy;

  int total = 0;
  int bad = 0;
  logic [DATA_W-1:0] refVal [NUM_TAGS];

  tlrf_top dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doAlloc(input int tag, input int cons);
    allocEn = 1'b1; allocTag = TAG_W'(tag); allocCons = CNT_W'(cons);
    tick();
    allocEn = 1'b0;
  endtask

  task automatic doWb(input int port, input int tag, input logic [DATA_W-1:0] d);
    wbEn[port] = 1'b1; wbTag[port] = TAG_W'(tag); wbData[port] = d;
    refVal[tag] = d;
    tick();
    wbEn = '0;
  endtask

  task automatic doRead(input logic [RD_PORTS-1:0] mask, input int tag);
    for (int p = 0; p < RD_PORTS; p++) rdTag[p] = TAG_W'(tag);
    rdEn = mask;
    tick();
    rdEn = '0;
  endtask

  task automatic probe(input int tag, input bit expHit, input string req);
    for (int p = 0; p < RD_PORTS; p++) rdTag[p] = TAG_W'(tag);
    #1;
    for (int p = 0; p < RD_PORTS; p++) begin
      check(rdHit[p] == expHit, req, 32'(rdHit[p]), 32'(expHit));
      if (expHit) check(rdData[p] == refVal[tag], req, rdData[p], refVal[tag]);
    end
  endtask

  task automatic t_reset();
    #1;
    check(allocReady == 1'b1, "R1 ready", 32'(allocReady), 1);
    probe(0, 1'b0, "R1 no hit");
    rstrEn = 1'b1; rstrTag = 0; rstrCons = 1;
    #1;
    check(rstrBusy == 1'b0, "R1 restore idle", 32'(rstrBusy), 0);
    tick();
    rstrEn = 1'b0;
    probe(0, 1'b0, "R1 restore no load");
  endtask

  task automatic t_drain();
    doAlloc(1, 3);
    probe(1, 1'b0, "R3 unwritten miss");
    doWb(0, 1, 32'hA5A5_0001);
    probe(1, 1'b1, "R3 written hit all ports");
    doRead(4'b0001, 1);
    tick();
    probe(1, 1'b1, "R4 count two left");
    doRead(4'b0110, 1);
    probe(1, 1'b1, "R5 still resident at zero");
    tick();
    probe(1, 1'b0, "R5 moved out");
  endtask

  task automatic t_addread();
    doAlloc(2, 1);
    doWb(1, 2, 32'h0BAD_0002);
    addEn = 1'b1; addTag = 2;
    doRead(4'b0100, 2);
    addEn = 1'b0;
    tick();
    probe(2, 1'b1, "R4 add and read cancel");
    doRead(4'b1000, 2);
    tick();
    probe(2, 1'b0, "R4 last read drains");
  endtask

  task automatic t_restore();
    rstrEn = 1'b1; rstrTag = 1; rstrCons = 1;
    #1;
    check(rstrBusy == 1'b0, "R6 no busy", 32'(rstrBusy), 0);
    tick();
    rstrEn = 1'b0;
    probe(1, 1'b1, "R6 restored data");
    doRead(4'b0001, 1);
    tick();
    probe(1, 1'b0, "R6 restored value drains");
    rstrEn = 1'b1; rstrTag = 2; rstrCons = 0;
    tick();
    rstrEn = 1'b0;
    probe(2, 1'b1, "R6 second restore");
    tick();
    probe(2, 1'b0, "R6 zero count moves back");
  endtask

  task automatic t_full();
    doAlloc(3, 1); doAlloc(4, 1); doAlloc(5, 1); doAlloc(6, 1);
    #1;
    check(allocReady == 1'b0, "R2 full refuses", 32'(allocReady), 0);
    rstrEn = 1'b1; rstrTag = 1; rstrCons = 1;
    #1;
    check(rstrBusy == 1'b1, "R7 busy when full", 32'(rstrBusy), 1);
    tick();
    probe(1, 1'b0, "R7 busy no load");
    rstrTag = 9;
    #1;
    check(rstrBusy == 1'b0, "R9 unknown tag no busy", 32'(rstrBusy), 0);
    rstrTag = 1;
    rstrEn = 1'b0;
    doWb(0, 3, 32'hC0DE_0003);
    doRead(4'b0001, 3);
    rstrEn = 1'b1;
    #1;
    check(rstrBusy == 1'b1, "R7 busy before move", 32'(rstrBusy), 1);
    tick();
    #1;
    check(rstrBusy == 1'b0, "R7 slot freed", 32'(rstrBusy), 0);
    check(allocReady == 1'b0, "R7 restore wins last slot", 32'(allocReady), 0);
    tick();
    rstrEn = 1'b0;
    probe(1, 1'b1, "R7 restore took slot");
    probe(9, 1'b0, "R9 unknown tag not loaded");
  endtask

  task automatic t_free();
    freeEn = 1'b1; freeTag = 4;
    tick();
    freeEn = 1'b0;
    #1;
    check(allocReady == 1'b1, "R8 free opens slot", 32'(allocReady), 1);
    for (int t = 5; t <= 6; t++) begin
      freeEn = 1'b1; freeTag = TAG_W'(t); tick();
    end
    freeEn = 1'b1; freeTag = 1; tick();
    freeEn = 1'b1; freeTag = 3; tick();
    freeEn = 1'b0;
    probe(1, 1'b0, "R8 freed resident gone");
    rstrEn = 1'b1; rstrTag = 3; rstrCons = 1;
    #1;
    check(rstrBusy == 1'b0, "R8 freed restore idle", 32'(rstrBusy), 0);
    tick();
    rstrEn = 1'b0;
    probe(3, 1'b0, "R8 freed restore ignored");
    rstrEn = 1'b1; rstrTag = 1;
    tick();
    rstrEn = 1'b0;
    probe(1, 1'b0, "R8 freed second level");
  endtask

  initial begin
    for (int t = 0; t < NUM_TAGS; t++) refVal[t] = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_drain();
    t_addread();
    t_restore();
    t_full();
    t_free();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule